// File: doc/BRIEF.md
# Interprocessor Interrupt Destination Resolver

This block takes an interprocessor interrupt command, issued as a pair of 32-bit words, and works out which of `NUM_AGENTS` processor agents the interrupt reaches. `NUM_AGENTS` is a parameter of at most 32. Each agent reports three values: an 8-bit physical ID, an 8-bit logical destination and a 4-bit addressing model. The sender also reports its own physical ID.

Writing the high word only latches the destination byte. Writing the low word starts a resolution. In the following cycle the block raises a one-cycle result. The result carries the agent mask, the vector, the delivery mode and the trigger mode, plus a flag that tells the masked agents to reload their arbitration IDs from their physical IDs. Per-agent interrupt state and the raising of SMI, NMI, INIT and startup signals belong to the agents and are not part of this block.

Top module: `ipi_route_top`

## Requirements
- R1: The cycle after each clock edge that samples `cmd_lo_wr` high, `dlv_valid` is 1 and `dlv_vector`, `dlv_mode` and `dlv_trig` equal low-word bits 7:0, 10:8 and 15 of that write. In every other cycle `dlv_valid`, `dlv_mask` and `dlv_arb_reset` are 0.
- R2: A high-word write stores bits 31:24 as the destination byte and produces no result. Later low-word writes use the stored byte. A high write in the same cycle as a low write takes effect from the next command.
- R3: Low-word bits 19:18 select the target set. 0 uses the addressed destination. 1 selects only agents whose ID equals `sender_id`. 2 selects all agents. 3 selects all agents except those whose ID equals `sender_id`.
- R4: With shorthand 0 and physical addressing (bit 11 = 0), destination 0xFF selects all agents. Any other destination selects the lowest-numbered agent whose ID equals it, or no agent if none does.
- R5: With shorthand 0 and logical addressing (bit 11 = 1), an agent with model 0xF matches when the destination AND its logical destination is nonzero.
- R6: In logical addressing, an agent with model 0x0 matches when the destination's upper nibble equals that of its logical destination and the AND of the lower nibbles is nonzero. Agents with any other model never match.
- R7: Delivery mode 1 (lowest priority) delivers to the lowest-numbered agent of the target set only.
- R8: Delivery mode 5 with bit 14 = 0 and bit 15 = 1 sets `dlv_arb_reset` and presents the target set as the mask. In every other case `dlv_arb_reset` is 0.
- R9: Delivery modes 0, 2, 4, 5, 6 and 7 present the full target set as the mask. Mode 3 is reserved and gives an empty mask.
- R10: After reset, `dlv_valid` and `dlv_mask` are 0 and the stored destination byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_lo_wr | input | 1 | Low command word write strobe; starts a resolution |
| cmd_lo | input | 32 | Low command word |
| cmd_hi_wr | input | 1 | High command word write strobe |
| cmd_hi | input | 32 | High command word (destination in 31:24) |
| sender_id | input | 8 | Physical ID of the issuing agent |
| agent_id | input | 8*NUM_AGENTS | Physical ID per agent, agent i in bits 8i+7:8i |
| agent_ldest | input | 8*NUM_AGENTS | Logical destination per agent |
| agent_model | input | 4*NUM_AGENTS | Addressing model per agent, agent i in bits 4i+3:4i |
| dlv_valid | output | 1 | One-cycle result strobe |
| dlv_mask | output | NUM_AGENTS | Agents that receive the command |
| dlv_vector | output | 8 | Vector |
| dlv_mode | output | 3 | Delivery mode |
| dlv_trig | output | 1 | Trigger mode |
| dlv_arb_reset | output | 1 | Masked agents reload their arbitration ID |

## Verification
The destination byte is the only state that persists between commands. If it is wrong, the error appears at the next shorthand-0 command as a wrong mask on that command's result cycle, and on no other output. An error in the result register appears at once: a missing or repeated `dlv_valid` strobe, or a mask that stays nonzero outside the strobe. Agent tables are drawn at random with few distinct ID values, so ID collisions, sender self-matches and both logical models occur often. Directed commands cover broadcast, no-match, reserved mode, the arbitration reset and lowest-priority narrowing.

// File: rtl/ipi_route_pkg.sv
`timescale 1ns/1ps
package ipi_route_pkg;

  localparam int ID_W    = 8;
  localparam int MODEL_W = 4;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'd0,
    DM_LOWPRI = 3'd1,
    DM_SMI    = 3'd2,
    DM_RSVD   = 3'd3,
    DM_NMI    = 3'd4,
    DM_INIT   = 3'd5,
    DM_START  = 3'd6,
    DM_EXTINT = 3'd7
  } dmode_e;

  typedef struct packed {
    logic [7:0] vector;
    dmode_e     dmode;
    logic       logical;
    logic       level;
    logic       trig;
    logic [1:0] shorthand;
  } cmd_t;

  // field extraction from the low command word
  function automatic cmd_t decode_lo(input logic [31:0] w);
    cmd_t c;
    c.vector    = w[7:0];
    c.dmode     = dmode_e'(w[10:8]);
    c.logical   = w[11];
    c.level     = w[14];
    c.trig      = w[15];
    c.shorthand = w[19:18];
    return c;
  endfunction

  // logical match for one agent under its addressing model
  function automatic logic logical_hit(input logic [ID_W-1:0] dest,
                                       input logic [ID_W-1:0] ldest,
                                       input logic [MODEL_W-1:0] model);
    logic hit;
    case (model)
      4'hF:    hit = |(dest & ldest);
      4'h0:    hit = (dest[7:4] == ldest[7:4]) && (|(dest[3:0] & ldest[3:0]));
      default: hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/ipi_agent_match.sv
`timescale 1ns/1ps
module ipi_agent_match
  import ipi_route_pkg::*;
(
  input  logic [ID_W-1:0]    dest,
  input  logic [ID_W-1:0]    sender,
  input  logic [ID_W-1:0]    my_id,
  input  logic [ID_W-1:0]    my_ldest,
  input  logic [MODEL_W-1:0] my_model,
  output logic               phys_hit,
  output logic               log_hit,
  output logic               self_hit
);
  assign phys_hit = (my_id == dest);
  assign log_hit  = logical_hit(dest, my_ldest, my_model);
  assign self_hit = (my_id == sender);
endmodule

// File: rtl/ipi_target_select.sv
`timescale 1ns/1ps
module ipi_target_select #(
  parameter int NUM_AGENTS = 8
) (
  input  logic [NUM_AGENTS-1:0] phys_hit,
  input  logic [NUM_AGENTS-1:0] log_hit,
  input  logic [NUM_AGENTS-1:0] self_hit,
  input  logic                  logical,
  input  logic [1:0]            shorthand,
  input  logic [7:0]            dest,
  output logic [NUM_AGENTS-1:0] target
);
  localparam logic [NUM_AGENTS-1:0] ALL = {NUM_AGENTS{1'b1}};

  function automatic logic [NUM_AGENTS-1:0] lowest_one(input logic [NUM_AGENTS-1:0] m);
    return m & (~m + 1'b1);
  endfunction

  logic [NUM_AGENTS-1:0] phys_sel;
  assign phys_sel = (dest == 8'hFF) ? ALL : lowest_one(phys_hit);

  always_comb begin
    case (shorthand)
      2'd0:    target = logical ? log_hit : phys_sel;
      2'd1:    target = self_hit;
      2'd2:    target = ALL;
      default: target = ~self_hit;
    endcase
  end
endmodule

// File: rtl/ipi_mode_filter.sv
`timescale 1ns/1ps
module ipi_mode_filter
  import ipi_route_pkg::*;
#(
  parameter int NUM_AGENTS = 8
) (
  input  logic [NUM_AGENTS-1:0] target,
  input  dmode_e                dmode,
  input  logic                  level,
  input  logic                  trig,
  output logic [NUM_AGENTS-1:0] mask,
  output logic                  arb_reset
);
  always_comb begin
    case (dmode)
      DM_LOWPRI: mask = target & (~target + 1'b1);
      DM_RSVD:   mask = '0;
      default:   mask = target;
    endcase
  end

  assign arb_reset = (dmode == DM_INIT) && !level && trig;
endmodule

// File: rtl/ipi_route_top.sv
`timescale 1ns/1ps
module ipi_route_top
  import ipi_route_pkg::*;
#(
  parameter int NUM_AGENTS = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cmd_lo_wr,
  input  logic [31:0]                   cmd_lo,
  input  logic                          cmd_hi_wr,
  input  logic [31:0]                   cmd_hi,
  input  logic [7:0]                    sender_id,
  input  logic [NUM_AGENTS*ID_W-1:0]    agent_id,
  input  logic [NUM_AGENTS*ID_W-1:0]    agent_ldest,
  input  logic [NUM_AGENTS*MODEL_W-1:0] agent_model,
  output logic                          dlv_valid,
  output logic [NUM_AGENTS-1:0]         dlv_mask,
  output logic [7:0]                    dlv_vector,
  output logic [2:0]                    dlv_mode,
  output logic                          dlv_trig,
  output logic                          dlv_arb_reset
);
  cmd_t                  cmd;
  logic [ID_W-1:0]       dest_q;
  logic [NUM_AGENTS-1:0] phys_hit, log_hit, self_hit;
  logic [NUM_AGENTS-1:0] target_mask;
  logic [NUM_AGENTS-1:0] final_mask;
  logic                  arb_rst;

  assign cmd = decode_lo(cmd_lo);

  always_ff @(posedge clk) begin
    if (!rst_n)         dest_q <= '0;
    else if (cmd_hi_wr) dest_q <= cmd_hi[31:24];
  end

  for (genvar g = 0; g < NUM_AGENTS; g++) begin : g_agent
    ipi_agent_match u_match (
      .dest     (dest_q),
      .sender   (sender_id),
      .my_id    (agent_id[g*ID_W +: ID_W]),
      .my_ldest (agent_ldest[g*ID_W +: ID_W]),
      .my_model (agent_model[g*MODEL_W +: MODEL_W]),
      .phys_hit (phys_hit[g]),
      .log_hit  (log_hit[g]),
      .self_hit (self_hit[g])
    );
  end

  ipi_target_select #(.NUM_AGENTS(NUM_AGENTS)) u_select (
    .phys_hit  (phys_hit),
    .log_hit   (log_hit),
    .self_hit  (self_hit),
    .logical   (cmd.logical),
    .shorthand (cmd.shorthand),
    .dest      (dest_q),
    .target    (target_mask)
  );

  ipi_mode_filter #(.NUM_AGENTS(NUM_AGENTS)) u_filter (
    .target    (target_mask),
    .dmode     (cmd.dmode),
    .level     (cmd.level),
    .trig      (cmd.trig),
    .mask      (final_mask),
    .arb_reset (arb_rst)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !cmd_lo_wr) begin
      dlv_valid     <= 1'b0;
      dlv_mask      <= '0;
      dlv_vector    <= '0;
      dlv_mode      <= '0;
      dlv_trig      <= 1'b0;
      dlv_arb_reset <= 1'b0;
    end else begin
      dlv_valid     <= 1'b1;
      dlv_mask      <= final_mask;
      dlv_vector    <= cmd.vector;
      dlv_mode      <= cmd.dmode;
      dlv_trig      <= cmd.trig;
      dlv_arb_reset <= arb_rst;
    end
  end
endmodule

// File: rtl/ipi_route_chk.sv
`timescale 1ns/1ps
module ipi_route_chk #(
  parameter int NUM_AGENTS = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cmd_lo_wr,
  input logic [31:0]           cmd_lo,
  input logic [NUM_AGENTS-1:0] target_mask,
  input logic                  dlv_valid,
  input logic [NUM_AGENTS-1:0] dlv_mask,
  input logic [7:0]            dlv_vector,
  input logic [2:0]            dlv_mode,
  input logic                  dlv_trig,
  input logic                  dlv_arb_reset
);
  // R1
  valid_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (dlv_valid == $past(cmd_lo_wr)));

  // R1
  idle_outputs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dlv_valid |-> (dlv_mask == '0 && !dlv_arb_reset));

  // R1
  vector_carried_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_lo_wr |=> (dlv_vector == $past(cmd_lo[7:0])));

  // R7
  lowpri_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && dlv_mode == 3'd1) |-> $onehot0(dlv_mask));

  // R9
  reserved_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && dlv_mode == 3'd3) |-> (dlv_mask == '0));

  // R9
  fixed_full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_lo_wr && cmd_lo[10:8] == 3'd0 |=> (dlv_mask == $past(target_mask)));

  // R8
  arb_reset_only_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_arb_reset |-> (dlv_valid && dlv_mode == 3'd5 && dlv_trig));
endmodule

bind ipi_route_top ipi_route_chk #(.NUM_AGENTS(NUM_AGENTS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_lo_wr     (cmd_lo_wr),
  .cmd_lo        (cmd_lo),
  .target_mask   (target_mask),
  .dlv_valid     (dlv_valid),
  .dlv_mask      (dlv_mask),
  .dlv_vector    (dlv_vector),
  .dlv_mode      (dlv_mode),
  .dlv_trig      (dlv_trig),
  .dlv_arb_reset (dlv_arb_reset)
);

// File: tb/ipi_route_top_tb_top.sv
`timescale 1ns/1ps
module ipi_route_top_tb_top;
  localparam int N = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_lo_wr = 1'b0;
  logic [31:0]   cmd_lo = '0;
  logic          cmd_hi_wr = 1'b0;
  logic [31:0]   cmd_hi = '0;
  logic [7:0]    sender_id = '0;
  logic [N*8-1:0] agent_id, agent_ldest;
  logic [N*4-1:0] agent_model;
  logic          dlv_valid, dlv_trig, dlv_arb_reset;
  logic [N-1:0]  dlv_mask;
  logic [7:0]    dlv_vector;
  logic [2:0]    dlv_mode;

  logic [7:0] a_id [N];
  logic [7:0] a_ld [N];
  logic [3:0] a_md [N];
  logic [7:0] tb_dest = 8'h00;
  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      agent_id[i*8 +: 8]    = a_id[i];
      agent_ldest[i*8 +: 8] = a_ld[i];
      agent_model[i*4 +: 4] = a_md[i];
    end
  end

  ipi_route_top #(.NUM_AGENTS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_lo_wr(cmd_lo_wr), .cmd_lo(cmd_lo),
    .cmd_hi_wr(cmd_hi_wr), .cmd_hi(cmd_hi), .sender_id(sender_id),
    .agent_id(agent_id), .agent_ldest(agent_ldest), .agent_model(agent_model),
    .dlv_valid(dlv_valid), .dlv_mask(dlv_mask), .dlv_vector(dlv_vector),
    .dlv_mode(dlv_mode), .dlv_trig(dlv_trig), .dlv_arb_reset(dlv_arb_reset)
  );

  task automatic cmp(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // target set per the addressing rules (R3..R6)
  function automatic logic [N-1:0] exp_target(input logic [31:0] lo);
    logic [N-1:0] t = '0;
    logic [N-1:0] self = '0;
    logic         found = 0;
    for (int i = 0; i < N; i++) self[i] = (a_id[i] == sender_id);
    case (lo[19:18])
      2'd1: t = self;
      2'd2: t = '1;
      2'd3: t = ~self;
      default: begin
        if (lo[11]) begin
          for (int i = 0; i < N; i++) begin
            if (a_md[i] == 4'hF)
              t[i] = (tb_dest & a_ld[i]) != 0;
            else if (a_md[i] == 4'h0)
              t[i] = (tb_dest[7:4] == a_ld[i][7:4]) && ((tb_dest[3:0] & a_ld[i][3:0]) != 0);
          end
        end else if (tb_dest == 8'hFF) begin
          t = '1;
        end else begin
          for (int i = 0; i < N; i++)
            if (!found && a_id[i] == tb_dest) begin t[i] = 1'b1; found = 1; end
        end
      end
    endcase
    return t;
  endfunction

  function automatic logic [N-1:0] exp_mask(input logic [31:0] lo);
    logic [N-1:0] t = exp_target(lo);
    logic [N-1:0] r = '0;
    if (lo[10:8] == 3'd3) return '0;               // R9
    if (lo[10:8] != 3'd1) return t;                // R9
    for (int i = N - 1; i >= 0; i--) if (t[i]) r = '0 | (N'(1) << i);  // R7
    return r;
  endfunction

  task automatic send(input logic [31:0] lo, input string req);
    logic [N-1:0] em;
    logic         ea;
    @(negedge clk);
    cmd_lo = lo; cmd_lo_wr = 1'b1;
    em = exp_mask(lo);
    ea = (lo[10:8] == 3'd5) && !lo[14] && lo[15];
    @(negedge clk);
    cmd_lo_wr = 1'b0;
    cmp("R1", "valid", 32'(dlv_valid), 32'd1);
    cmp("R1", "vector", 32'(dlv_vector), 32'(lo[7:0]));
    cmp("R1", "mode", 32'(dlv_mode), 32'(lo[10:8]));
    cmp("R1", "trig", 32'(dlv_trig), 32'(lo[15]));
    cmp(req, "mask", 32'(dlv_mask), 32'(em));
    cmp("R8", "arb_reset", 32'(dlv_arb_reset), 32'(ea));
    @(negedge clk);
    cmp("R1", "valid after pulse", 32'(dlv_valid), 32'd0);
    cmp("R1", "mask after pulse", 32'(dlv_mask), 32'd0);
  endtask

  task automatic write_hi(input logic [7:0] d);
    @(negedge clk);
    cmd_hi = {d, 24'h5A5A5A}; cmd_hi_wr = 1'b1;
    @(negedge clk);
    cmd_hi_wr = 1'b0;
    tb_dest = d;
    cmp("R2", "no result on high write", 32'(dlv_valid), 32'd0);
  endtask

  function automatic logic [31:0] mk(input logic [7:0] vec, input logic [2:0] dm,
      input logic lg, input logic lvl, input logic trg, input logic [1:0] sh);
    return {12'h0, sh, 2'b00, trg, lvl, 2'b00, lg, dm, vec};
  endfunction

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin a_id[i] = 8'(i); a_ld[i] = 8'(1 << i); a_md[i] = 4'hF; end
    repeat (3) @(negedge clk);
    // R10 reset state
    cmp("R10", "valid in reset", 32'(dlv_valid), 32'd0);
    cmp("R10", "mask in reset", 32'(dlv_mask), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R10", "valid after reset", 32'(dlv_valid), 32'd0);
    // R10: stored destination is 0 -> agent 0 selected physically
    send(mk(8'h31, 3'd0, 0, 1, 0, 2'd0), "R10");
    // R4 broadcast, single and no-match
    write_hi(8'hFF); send(mk(8'h40, 3'd0, 0, 1, 0, 2'd0), "R4");
    write_hi(8'h05); send(mk(8'h41, 3'd0, 0, 1, 0, 2'd0), "R4");
    write_hi(8'h77); send(mk(8'h42, 3'd0, 0, 1, 0, 2'd0), "R4");
    // R4 duplicate IDs: lowest-numbered wins
    a_id[6] = 8'h03; write_hi(8'h03); send(mk(8'h43, 3'd0, 0, 1, 0, 2'd0), "R4");
    // R5 flat logical
    write_hi(8'h24); send(mk(8'h50, 3'd0, 1, 1, 0, 2'd0), "R5");
    // R6 cluster logical and unsupported model
    a_md[1] = 4'h0; a_ld[1] = 8'h31; a_md[2] = 4'h0; a_ld[2] = 8'h21; a_md[3] = 4'h5;
    write_hi(8'h33); send(mk(8'h51, 3'd0, 1, 1, 0, 2'd0), "R6");
    // R3 shorthands
    sender_id = 8'h03;
    send(mk(8'h60, 3'd0, 0, 1, 0, 2'd1), "R3");
    send(mk(8'h61, 3'd0, 0, 1, 0, 2'd2), "R3");
    send(mk(8'h62, 3'd0, 0, 1, 0, 2'd3), "R3");
    // R7 lowest priority over all-but-self
    send(mk(8'h70, 3'd1, 0, 1, 0, 2'd3), "R7");
    // R8 INIT deassert and a normal INIT
    send(mk(8'h00, 3'd5, 0, 0, 1, 2'd2), "R8");
    send(mk(8'h00, 3'd5, 0, 1, 1, 2'd2), "R8");
    // R9 reserved mode and other modes
    send(mk(8'h90, 3'd3, 0, 1, 0, 2'd2), "R9");
    for (int m = 0; m < 8; m++) send(mk(8'h91, 3'(m), 0, 1, 0, 2'd2), "R9");
    // R2 simultaneous high and low write: old destination used
    write_hi(8'h02);
    @(negedge clk);
    cmd_hi = {8'h04, 24'h0}; cmd_hi_wr = 1'b1;
    cmd_lo = mk(8'hA0, 3'd0, 0, 1, 0, 2'd0); cmd_lo_wr = 1'b1;
    @(negedge clk);
    cmd_hi_wr = 1'b0; cmd_lo_wr = 1'b0;
    cmp("R2", "mask uses prior dest", 32'(dlv_mask), 32'(exp_mask(mk(8'hA0, 3'd0, 0, 1, 0, 2'd0))));
    tb_dest = 8'h04;
    send(mk(8'hA1, 3'd0, 0, 1, 0, 2'd0), "R2");
    // random mix
    for (int k = 0; k < 300; k++) begin
      for (int i = 0; i < N; i++) begin
        a_id[i] = 8'($urandom_range(0, 6));
        a_ld[i] = 8'($urandom);
        case ($urandom_range(0, 2))
          0: a_md[i] = 4'hF;
          1: a_md[i] = 4'h0;
          default: a_md[i] = 4'($urandom);
        endcase
      end
      sender_id = 8'($urandom_range(0, 6));
      if ($urandom_range(0, 1) == 1) begin
        case ($urandom_range(0, 3))
          0: write_hi(8'hFF);
          1: write_hi(8'($urandom_range(0, 7)));
          default: write_hi(8'($urandom));
        endcase
      end
      send($urandom, "R9");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule